// File: doc/BRIEF.md
# Four-Stage Fork/Join Streaming Square-Sum Pipeline

The block streams 32-bit words through four small state machines that run at the same time and talk to each other only through shallow FIFOs. Every input word `a` yields one output word `f = (9a)^2 + (2a)^2`, with all arithmetic wrapping at 32 bits. The first stage forks each word into two scaled copies (nine times and two times the input) and writes them to two separate FIFOs. Two middle stages each square one of those streams into their own FIFO. The last stage joins the two squared streams by adding matching elements and presents the sum on a valid/ready output.

A run begins with a one-cycle `start` pulse that samples the element count, clears every stage counter, flag and FIFO. Each stage counts the elements it has finished and marks itself finished when that count reaches the sampled value. The top-level `done` output is the AND of the four stage flags and remains high until the next `start`. Because the stages overlap, a middle stage works on element i while the fork stage already handles element i+1.

Every stage runs the same three-state cycle. `PH_IDLE` waits while the stage is finished or no run has been started, and moves to `PH_FETCH` once a run is active and unfinished. `PH_FETCH` holds until its input side has data, then takes one element (popping its FIFO, or completing an input handshake) and moves to `PH_EMIT`. `PH_EMIT` holds while its output side has no room, then writes its result, bumps its count and returns to `PH_IDLE`. A `start` forces every stage back to `PH_IDLE`.

Top module: `dataflow_pipe`

## Requirements
- R1: For every accepted input word a, exactly one output word equal to (9a)^2 + (2a)^2 is produced, and outputs appear in input order.
- R2: All products and the final sum wrap modulo 2^32 (an input of 0xFFFFFFFF gives 85).
- R3: After `start`, `in_ready` is offered for exactly `elem_count` input handshakes; once those are taken, `in_ready` stays low until the next `start`.
- R4: A stage never writes a full FIFO nor reads an empty one; with the output held back the pipeline fills, `in_ready` drops and no data is lost.
- R5: The join stage takes a pair only when both squared-value FIFOs are non-empty.
- R6: `done` is the AND of the four stage finished flags: it is low until the last output handshake has happened, then rises, and every FIFO is empty while it is high.
- R7: Once high, `done` stays high until a `start` pulse, which clears it on the following cycle when `elem_count` is non-zero.
- R8: A `start` with `elem_count` equal to 0 sets `done` one cycle later with no input accepted and no output produced.
- R9: After reset, `done`, `in_ready` and `out_valid` are all low.
- R10: While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_data` keeps its value.
- R11: The stages overlap: an eight-element run with `out_ready` held high completes in fewer than 64 cycles from `start` (a stage-after-stage schedule needs about 96).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| elem_count | input | CNT_W (16) | Elements in the run, sampled on `start` |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W (32) | Input word a |
| in_ready | output | 1 | Fork stage will take the input word this cycle |
| out_valid | output | 1 | Result word present |
| out_data | output | DATA_W (32) | Result word f |
| out_ready | input | 1 | Consumer takes the result this cycle |
| done | output | 1 | All four stages finished the run |

## Verification
The bench targets the wrap of large inputs (a design with a wider or signed product would return a wrong sum for 0xFFFFFFFF and 0x80000000), a held-back output that fills all FIFOs (a design that skipped a full check would drop or duplicate words, or let `out_data` change while waiting), and the exact edge where `done` rises (a design that raised it when the fork stage finished would show `done` before the last output handshake). It also covers a zero-length run, which a design comparing only after an increment would never finish, the persistence of `done` until `start`, the closing of `in_ready` after the configured count, and a run-time bound that a design serialising the stages would miss.

// File: rtl/df_pkg.sv
`timescale 1ns/1ps
package df_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_EMIT  = 2'd2
    } phase_t;

    localparam int NUM_STAGES = 4;
    localparam int NUM_QUEUES = 4;
    // queue indices
    localparam int Q_NINE = 0;
    localparam int Q_TWO  = 1;
    localparam int Q_SQN  = 2;
    localparam int Q_SQT  = 3;
endpackage

// File: rtl/df_fifo.sv
`timescale 1ns/1ps
module df_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     fill_q, fill_d;
    logic              push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_comb begin
        fill_d = fill_q;
        if (push_ok && !pop_ok) fill_d = fill_q + CW'(1);
        else if (pop_ok && !push_ok) fill_d = fill_q - CW'(1);
    end

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
            empty  <= 1'b1;
            full   <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            fill_q <= fill_d;
            empty  <= (fill_d == '0);
            full   <= (fill_d == CW'(DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // R4: writers must respect the full flag
    assert_no_push_full_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R4: readers must respect the empty flag
    assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/df_stage_ctrl.sv
`timescale 1ns/1ps
module df_stage_ctrl
    import df_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             avail,
    input  logic             space,
    output logic             fetching,
    output logic             emitting,
    output logic             take,
    output logic             give,
    output logic             fin
);
    phase_t           state, nxt;
    logic [CNT_W-1:0] cnt_q, lim_q;
    logic             armed_q;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE:  if (armed_q && !fin) nxt = PH_FETCH;
            PH_FETCH: if (avail) nxt = PH_EMIT;
            PH_EMIT:  if (space) nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst || start) state <= PH_IDLE;
        else              state <= nxt;
    end

    // outputs
    always_comb begin
        fetching = (state == PH_FETCH);
        emitting = (state == PH_EMIT);
        take     = fetching && avail;
        give     = emitting && space;
    end

    // progress counter and finished flag
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            lim_q   <= '0;
            fin     <= 1'b0;
            armed_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            lim_q   <= cfg_count;
            fin     <= (cfg_count == '0);
            armed_q <= 1'b1;
        end else if (give) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q + CNT_W'(1) == lim_q) fin <= 1'b1;
        end
    end

    // R3: a stage never handles more elements than configured
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q);
    // R7: the finished flag is cleared only by start
    assert_fin_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (fin && !start) |=> fin);
endmodule

// File: rtl/dataflow_pipe.sv
`timescale 1ns/1ps
module dataflow_pipe
    import df_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  elem_count,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              done
);
    logic [NUM_STAGES-1:0] avail, space, fetching, emitting, take, give, fin;
    logic [NUM_QUEUES-1:0] q_push, q_pop, q_empty, q_full;
    logic [DATA_W-1:0]     q_wdata [NUM_QUEUES];
    logic [DATA_W-1:0]     q_rdata [NUM_QUEUES];

    // per-stage result registers
    logic [DATA_W-1:0] nine_q, two_q, sqn_q, sqt_q, sum_q;

    // stage readiness wiring: fork, square(9a), square(2a), join
    assign avail[0] = in_valid;
    assign avail[1] = !q_empty[Q_NINE];
    assign avail[2] = !q_empty[Q_TWO];
    assign avail[3] = !q_empty[Q_SQN] && !q_empty[Q_SQT];

    assign space[0] = !q_full[Q_NINE] && !q_full[Q_TWO];
    assign space[1] = !q_full[Q_SQN];
    assign space[2] = !q_full[Q_SQT];
    assign space[3] = out_ready;

    assign q_push[Q_NINE] = give[0];
    assign q_push[Q_TWO]  = give[0];
    assign q_push[Q_SQN]  = give[1];
    assign q_push[Q_SQT]  = give[2];

    assign q_pop[Q_NINE] = take[1];
    assign q_pop[Q_TWO]  = take[2];
    assign q_pop[Q_SQN]  = take[3];
    assign q_pop[Q_SQT]  = take[3];

    assign q_wdata[Q_NINE] = nine_q;
    assign q_wdata[Q_TWO]  = two_q;
    assign q_wdata[Q_SQN]  = sqn_q;
    assign q_wdata[Q_SQT]  = sqt_q;

    genvar g;
    generate
        for (g = 0; g < NUM_STAGES; g++) begin : g_stage
            df_stage_ctrl #(.CNT_W(CNT_W)) u_ctrl (
                .clk       (clk),
                .rst       (rst),
                .start     (start),
                .cfg_count (elem_count),
                .avail     (avail[g]),
                .space     (space[g]),
                .fetching  (fetching[g]),
                .emitting  (emitting[g]),
                .take      (take[g]),
                .give      (give[g]),
                .fin       (fin[g])
            );
        end
        for (g = 0; g < NUM_QUEUES; g++) begin : g_queue
            df_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
                .clk   (clk),
                .rst   (rst),
                .flush (start),
                .push  (q_push[g]),
                .pop   (q_pop[g]),
                .wdata (q_wdata[g]),
                .rdata (q_rdata[g]),
                .empty (q_empty[g]),
                .full  (q_full[g])
            );
        end
    endgenerate

    // datapath: each stage computes when it takes its operands
    always_ff @(posedge clk) begin
        if (rst) begin
            nine_q <= '0;
            two_q  <= '0;
            sqn_q  <= '0;
            sqt_q  <= '0;
            sum_q  <= '0;
        end else begin
            if (take[0]) begin
                nine_q <= in_data * DATA_W'(9);
                two_q  <= in_data * DATA_W'(2);
            end
            if (take[1]) sqn_q <= q_rdata[Q_NINE] * q_rdata[Q_NINE];
            if (take[2]) sqt_q <= q_rdata[Q_TWO] * q_rdata[Q_TWO];
            if (take[3]) sum_q <= q_rdata[Q_SQN] + q_rdata[Q_SQT];
        end
    end

    assign in_ready  = fetching[0];
    assign out_valid = emitting[3];
    assign out_data  = sum_q;
    assign done      = &fin;

    // R5: the join pops only when both squared streams hold data
    assert_join_both_R5: assert property (@(posedge clk) disable iff (rst)
        take[3] |-> (!q_empty[Q_SQN] && !q_empty[Q_SQT]));
    // R6: a finished run leaves every queue drained
    assert_done_drained_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (&q_empty));
    // R10: a waiting result is held
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));
    // R9: nothing is offered straight out of reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!done && !in_ready && !out_valid));
endmodule

// File: tb/dataflow_pipe_bench.sv
`timescale 1ns/1ps
module dataflow_pipe_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] elem_count = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b0;
    logic        done;

    always #2.5 clk = ~clk;

    dataflow_pipe u_dataflow_pipe (
        .clk(clk), .rst(rst), .start(start), .elem_count(elem_count),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .done(done)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ready_mode = 0;
    bit release_out = 1'b0;
    int outs = 0;
    int acc_cnt = 0;
    logic [31:0] vals [32];
    logic [31:0] exp_q [$];
    bit          held_v = 1'b0;
    logic [31:0] held_d = '0;

    function automatic logic [31:0] model(input logic [31:0] a);
        logic [31:0] x, y;
        x = a * 32'd9;
        y = a * 32'd2;
        return x * x + y * y;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // output side: set ready first, then observe what the next edge will do
    always @(negedge clk) begin
        cyc++;
        unique case (ready_mode)
            1:       out_ready = (cyc % 3) != 0;
            2:       out_ready = release_out;
            default: out_ready = 1'b1;
        endcase
        if (!rst) begin
            if (held_v) begin
                check(out_valid, "R10 valid held", {31'd0, out_valid}, 32'd1);
                check(out_data == held_d, "R10 data held", out_data, held_d);
            end
            if (out_valid && out_ready) begin
                logic [31:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEADBEEF;
                check(out_data == e, "R1 result", out_data, e);
                check(!done, "R6 done before last output", {31'd0, done}, 32'd0);
                outs++;
            end
            held_v = out_valid && !out_ready;
            held_d = out_data;
        end
    end

    task automatic drive(input int n);
        for (int i = 0; i < n; i++) begin
            bit acc;
            in_valid = 1'b1;
            in_data  = vals[i];
            do begin
                acc = in_ready;
                @(negedge clk);
            end while (!acc);
            acc_cnt++;
        end
        in_valid = 1'b0;
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk);
        start = 1'b1;
        elem_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_job(input int n, input int mode, input string tag,
                           output int cycles);
        outs = 0;
        acc_cnt = 0;
        exp_q.delete();
        for (int i = 0; i < n; i++) exp_q.push_back(model(vals[i]));
        ready_mode = mode;
        release_out = 1'b0;
        pulse_start(n);
        cycles = 1;
        check(!done, {tag, " R7 done cleared by start"}, {31'd0, done}, 32'd0);
        fork
            drive(n);
        join_none
        if (mode == 2) begin
            int snap;
            repeat (60) @(negedge clk);
            snap = acc_cnt;
            repeat (10) @(negedge clk);
            cycles += 70;
            check(acc_cnt == snap && snap < n, {tag, " R4 input stalled"}, 32'(acc_cnt), 32'(snap));
            check(!in_ready, {tag, " R4 in_ready low when full"}, {31'd0, in_ready}, 32'd0);
            check(outs == 0, {tag, " R4 no output while held"}, 32'(outs), 32'd0);
            release_out = 1'b1;
        end
        while (!done && cycles < 3000) begin
            @(negedge clk);
            cycles++;
        end
        check(done, {tag, " R6 done rises"}, {31'd0, done}, 32'd1);
        check(outs == n, {tag, " R1 output count"}, 32'(outs), 32'(n));
        check(acc_cnt == n, {tag, " R3 input count"}, 32'(acc_cnt), 32'(n));
        @(negedge clk);
        check(!in_ready, {tag, " R3 in_ready closed after count"}, {31'd0, in_ready}, 32'd0);
    endtask

    task automatic t_reset();
        check(!done, "R9 reset done", {31'd0, done}, 32'd0);
        check(!in_ready, "R9 reset in_ready", {31'd0, in_ready}, 32'd0);
        check(!out_valid, "R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_basic();
        int c;
        vals[0] = 0; vals[1] = 1; vals[2] = 2; vals[3] = 3; vals[4] = 100;
        run_job(5, 0, "basic", c);
    endtask

    task automatic t_wrap();
        int c;
        vals[0] = 32'hFFFF_FFFF; vals[1] = 32'h8000_0000; vals[2] = 32'h1234_5678;
        run_job(3, 1, "wrap", c);
        check(model(32'hFFFF_FFFF) == 32'd85, "R2 wrap model", model(32'hFFFF_FFFF), 32'd85);
    endtask

    task automatic t_backpressure();
        int c;
        for (int i = 0; i < 20; i++) vals[i] = 32'(i * 7919 + 13);
        run_job(20, 2, "stall", c);
    endtask

    task automatic t_zero();
        outs = 0;
        exp_q.delete();
        ready_mode = 0;
        in_valid = 1'b1;
        in_data = 32'd5;
        pulse_start(0);
        check(done, "R8 zero count done", {31'd0, done}, 32'd1);
        check(!in_ready, "R8 zero count no input", {31'd0, in_ready}, 32'd0);
        repeat (5) @(negedge clk);
        check(outs == 0 && !in_ready, "R8 zero count quiet", 32'(outs), 32'd0);
        in_valid = 1'b0;
    endtask

    task automatic t_hold();
        int c;
        vals[0] = 32'd11; vals[1] = 32'd12;
        run_job(2, 0, "hold", c);
        repeat (12) @(negedge clk);
        check(done, "R7 done held until start", {31'd0, done}, 32'd1);
        vals[0] = 32'd40; vals[1] = 32'd41;
        run_job(2, 1, "restart", c);
    endtask

    task automatic t_overlap();
        int c;
        for (int i = 0; i < 8; i++) vals[i] = 32'(i + 1000);
        run_job(8, 0, "overlap", c);
        check(c < 64, "R11 overlapped run time", 32'(c), 32'd64);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_backpressure();
        t_zero();
        t_hold();
        t_overlap();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule